// File: doc/BRIEF.md
# Observation and Control Test-Point Shell

This block wraps a group of hard-to-reach nets with test points. A row of observation cells samples chosen internal nodes and, once switched to shifting, moves the captured bits out one per clock on a single serial pin. A set of control points sits between the source and destination ends of selected nets. Each control point has its own flip-flop and a two-way selector, so that in test mode the net's destination can be driven from the flip-flop instead of from its source.

All test-point flip-flops form one serial chain. The control flip-flops come first and the observation cells follow, so a single shift sequence both loads the forced values and unloads the captured node values. A scan-enable input chooses between shifting and capturing. A test-mode input chooses what drives the overridden nets. With both inputs low, every destination net carries exactly its source value.

Top module: `tp_shell`

## Requirements
- R1: A synchronous reset clears every test-point flip-flop. After reset, `scan_out` is 0, and with `test_mode` at 1 every `ctl_dst` bit is 0.
- R2: With `scan_en` at 0, observation cell i loads `obs_node[i]` on each rising clock edge.
- R3: With `scan_en` at 1, every chain flip-flop loads its predecessor on each rising edge. The order is `scan_in` → control flip-flop 0 … control flip-flop NCTL-1 → observation cell 0 … observation cell NOBS-1 → `scan_out`.
- R4: `scan_out` is the registered value of the last observation cell. After a capture, the value of `obs_node[i]` appears on `scan_out` after NOBS-1-i shift clocks, so node 0 comes out last.
- R5: With `scan_en` at 0, the control flip-flops keep their value whatever `scan_in` does.
- R6: With `test_mode` at 0, `ctl_dst[j]` equals `ctl_src[j]` in the same cycle, whatever the chain holds.
- R7: With `test_mode` at 1, `ctl_dst[j]` equals control flip-flop j, and `ctl_src` has no effect. This includes cycles in which that flip-flop is shifting.
- R8: A capture (`scan_en` at 0) while `test_mode` is 1 loads the observation cells normally and does not change the forced destination values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | 1: chain shifts; 0: observation cells capture and control flip-flops hold |
| test_mode | input | 1 | 1: control flip-flops drive the destination nets |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output (last observation cell) |
| obs_node | input | NOBS | Low-observability nodes to be sampled |
| ctl_src | input | NCTL | Source ends of the controlled nets |
| ctl_dst | output | NCTL | Destination ends of the controlled nets |

## Verification
Two functions can fall in the same cycle. The first is the override of the destination nets, which reads the control flip-flops. The second is the chain's own movement, either a capture into the observation cells or a shift through the control flip-flops. The bench provokes this by holding `test_mode` high through whole capture and shift phases while `ctl_src` and `scan_in` keep changing. A behavioural model of the chain then judges `ctl_dst` and `scan_out` in every cycle. During shifting the forced values must ripple bit by bit. During capture they must stay frozen while the node values still land in the observation cells.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // total number of flip-flops on the serial chain
  function automatic int chain_len(input int n_obs, input int n_ctl);
    return n_obs + n_ctl;
  endfunction

  // next value of an observation cell
  function automatic logic obs_next(input logic shift, input logic prev, input logic node);
    return shift ? prev : node;
  endfunction

  // value presented at a controlled destination
  function automatic logic ctl_pick(input logic force_en, input logic forced, input logic src);
    return force_en ? forced : src;
  endfunction

endpackage

// File: rtl/tp_obs_cell.sv
module tp_obs_cell (
  input  logic clk,
  input  logic rst,
  input  logic shift,
  input  logic node,
  input  logic prev,
  output logic q
);
  import tp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= obs_next(shift, prev, node);
  end

  AST_OBS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(shift)) |-> (q == $past(node))); // R2
  AST_OBS_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(shift)) |-> (q == $past(prev))); // R3
  AST_OBS_RESET: assert property (@(posedge clk)
    $past(rst) |-> (q == 1'b0)); // R1

endmodule

// File: rtl/tp_ctl_point.sv
module tp_ctl_point (
  input  logic clk,
  input  logic rst,
  input  logic shift,
  input  logic force_en,
  input  logic prev,
  input  logic src,
  output logic q,
  output logic dst
);
  import tp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (shift) q <= prev;
  end

  assign dst = ctl_pick(force_en, q, src);

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(shift)) |-> $stable(q)); // R5
  AST_CTL_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(shift)) |-> (q == $past(prev))); // R3
  AST_CTL_FORCED: assert property (@(posedge clk) disable iff (rst)
    force_en |-> (dst == q)); // R7

endmodule

// File: rtl/tp_shell.sv
module tp_shell #(
  parameter int NOBS = 4,
  parameter int NCTL = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scan_en,
  input  logic            test_mode,
  input  logic            scan_in,
  output logic            scan_out,
  input  logic [NOBS-1:0] obs_node,
  input  logic [NCTL-1:0] ctl_src,
  output logic [NCTL-1:0] ctl_dst
);
  import tp_pkg::*;

  localparam int CHAIN = chain_len(NOBS, NCTL);

  // link[k] feeds chain flip-flop k; link[k+1] is its output
  logic [CHAIN:0] link;
  assign link[0] = scan_in;

  for (genvar j = 0; j < NCTL; j++) begin : g_ctl
    tp_ctl_point u_ctl (
      .clk      (clk),
      .rst      (rst),
      .shift    (scan_en),
      .force_en (test_mode),
      .prev     (link[j]),
      .src      (ctl_src[j]),
      .q        (link[j+1]),
      .dst      (ctl_dst[j])
    );
  end

  for (genvar i = 0; i < NOBS; i++) begin : g_obs
    tp_obs_cell u_obs (
      .clk   (clk),
      .rst   (rst),
      .shift (scan_en),
      .node  (obs_node[i]),
      .prev  (link[NCTL+i]),
      .q     (link[NCTL+i+1])
    );
  end

  assign scan_out = link[CHAIN];

  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    !test_mode |-> (ctl_dst == ctl_src)); // R6
  AST_RESET_OUT: assert property (@(posedge clk)
    $past(rst) |-> (scan_out == 1'b0)); // R1
  AST_LAST_NODE_OUT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(scan_en)) |-> (scan_out == $past(obs_node[NOBS-1]))); // R4

endmodule

// File: tb/tp_shell_tb.sv
module tp_shell_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NOBS = 4;
  localparam int NCTL = 3;
  localparam int LEN  = NOBS + NCTL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_en = 1'b0, test_mode = 1'b0, scan_in = 1'b0;
  logic [NOBS-1:0] obs_node = '0;
  logic [NCTL-1:0] ctl_src = '0;
  logic scan_out;
  logic [NCTL-1:0] ctl_dst;

  int compared = 0, mismatched = 0;
  string tag = "R1";
  bit done = 0;

  // model: position 0 is nearest scan_in
  bit mdl [LEN];

  tp_shell #(.NOBS(NOBS), .NCTL(NCTL)) dut_i (
    .clk(clk), .rst(rst), .scan_en(scan_en), .test_mode(test_mode),
    .scan_in(scan_in), .scan_out(scan_out), .obs_node(obs_node),
    .ctl_src(ctl_src), .ctl_dst(ctl_dst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      foreach (mdl[k]) mdl[k] = 1'b0;
    end else if (scan_en) begin
      for (int k = LEN-1; k > 0; k--) mdl[k] = mdl[k-1];
      mdl[0] = scan_in;
    end else begin
      for (int i = 0; i < NOBS; i++) mdl[NCTL+i] = obs_node[i];
    end
    #(CLK_PERIOD/4);
    if (!done) begin
      compared++;
      if (scan_out !== mdl[LEN-1]) begin
        mismatched++;
        $display("FAIL %s scan_out actual=%b expected=%b t=%0t", tag, scan_out, mdl[LEN-1], $time);
      end
      for (int j = 0; j < NCTL; j++) begin
        compared++;
        if (ctl_dst[j] !== (test_mode ? mdl[j] : ctl_src[j])) begin
          mismatched++;
          $display("FAIL %s ctl_dst[%0d] actual=%b expected=%b t=%0t", tag, j, ctl_dst[j],
                   test_mode ? mdl[j] : ctl_src[j], $time);
        end
      end
    end
  end

  task automatic step(input logic se, input logic tm, input logic si,
                      input logic [NOBS-1:0] nd, input logic [NCTL-1:0] src);
    @(negedge clk);
    scan_en = se; test_mode = tm; scan_in = si; obs_node = nd; ctl_src = src;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    mismatched++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    // R1: reset with forcing on, outputs cleared
    test_mode = 1'b1; scan_in = 1'b1; obs_node = '1; ctl_src = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6: transparency with changing sources, chain loaded with ones
    tag = "R6";
    for (int n = 0; n < 6; n++) step(1'b1, 1'b0, 1'b1, NOBS'(n), NCTL'(n*5));
    for (int n = 0; n < 10; n++) step(1'b0, 1'b0, n[0], NOBS'($urandom), NCTL'($urandom));
    // R2 / R4: capture a pattern, then unload node values serially
    tag = "R2";
    step(1'b0, 1'b0, 1'b0, 4'b1011, '0);
    tag = "R4";
    for (int n = 0; n < NOBS+1; n++) step(1'b1, 1'b0, 1'b0, 4'b0100, '0);
    tag = "R2";
    step(1'b0, 1'b0, 1'b1, 4'b0110, '1);
    tag = "R4";
    for (int n = 0; n < NOBS; n++) step(1'b1, 1'b0, 1'b1, 4'b1001, '1);
    // R3 / R7: shift forced values in with forcing on, ripple observed
    tag = "R7";
    for (int n = 0; n < LEN; n++) step(1'b1, 1'b1, n[1] ^ n[0], NOBS'($urandom), NCTL'($urandom));
    tag = "R3";
    for (int n = 0; n < 2*LEN; n++) step(1'b1, n[2], n[0], NOBS'($urandom), NCTL'($urandom));
    // R5: hold control flops with scan_in toggling
    tag = "R5";
    for (int n = 0; n < 8; n++) step(1'b0, 1'b1, n[0], NOBS'($urandom), NCTL'($urandom));
    // R8: capture while forcing, then unload
    tag = "R8";
    for (int n = 0; n < 6; n++) begin
      step(1'b0, 1'b1, 1'b1, NOBS'($urandom), NCTL'($urandom));
      step(1'b1, 1'b1, n[0], NOBS'($urandom), NCTL'($urandom));
    end
    // mixed random traffic
    tag = "R3";
    for (int n = 0; n < 200; n++)
      step(1'($urandom), 1'($urandom), 1'($urandom), NOBS'($urandom), NCTL'($urandom));
    // R1: reset in the middle of activity
    tag = "R1";
    @(negedge clk); rst = 1'b1; test_mode = 1'b1; scan_en = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    step(1'b0, 1'b1, 1'b0, '0, '1);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule